// File: doc/BRIEF.md
# BCD to one-of-ten decoder

This block turns a single 4-bit binary-coded decimal digit into ten select lines, one for each decimal value from 0 to 9. The select lines are active low. A legal digit pulls exactly one line low. The six codes above nine are refused: every line stays high, and a separate active-high flag reports the refusal. A refused code is never mapped onto one of the ten digits.

The block is purely combinational, with no clock, no reset and no stored state. It is meant for selecting one of ten targets from a decimal digit, where a corrupted or out-of-range digit must select nothing.

Top module: `bcd_onehot_dec`

## Requirements
- R1: `code_i` is read as an unsigned binary value, with bit 3 the most significant bit and bit 0 the least significant bit.
- R2: When the value v of `code_i` is from 0 to 9, `sel_n_o[v]` is 0 and the other nine bits of `sel_n_o` are 1.
- R3: When the value of `code_i` is from 10 to 15, all ten bits of `sel_n_o` are 1.
- R4: `invalid_o` is 1 when the value of `code_i` is from 10 to 15, and 0 when it is from 0 to 9.
- R5: At most one bit of `sel_n_o` is 0 at any time.
- R6: The outputs depend only on the present value of `code_i`. The same code gives the same outputs whatever codes were applied before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| code_i | input | 4 | BCD digit; bit 3 is the MSB |
| sel_n_o | output | 10 | Active-low select lines; bit v goes low for digit v |
| invalid_o | output | 1 | High when the code is above nine |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between `code_i` and the outputs. The bench changes the code, waits a fixed settling delay with no clock edge in between, and then samples both outputs. It also counts the low select lines on every vector. The bench replays codes after different predecessors to show that earlier codes have no effect on the result.

// File: rtl/bcd_dec_pkg.sv
package bcd_dec_pkg;
    localparam int unsigned DIGITS = 10;
    localparam int unsigned CODE_W = $clog2(DIGITS);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [DIGITS-1:0] sel_t;

    typedef struct packed {
        sel_t sel_hot;
        logic bad;
    } dec_t;
endpackage

// File: rtl/bcd_range_chk.sv
module bcd_range_chk #(
    parameter int unsigned CODE_W = 4,
    parameter int unsigned LIMIT  = 10
) (
    input  logic [CODE_W-1:0] code_i,
    output logic              bad_o
);
    localparam logic [CODE_W:0] LIMIT_V = LIMIT[CODE_W:0];

    always_comb begin
        bad_o = ({1'b0, code_i} >= LIMIT_V);
    end
endmodule

// File: rtl/bcd_onehot_gen.sv
module bcd_onehot_gen #(
    parameter int unsigned CODE_W = 4,
    parameter int unsigned DIGITS = 10
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              enable_i,
    output logic [DIGITS-1:0] hot_o
);
    for (genvar k = 0; k < DIGITS; k++) begin : g_line
        localparam logic [CODE_W-1:0] MATCH = k[CODE_W-1:0];
        assign hot_o[k] = enable_i && (code_i == MATCH);
    end
endmodule

// File: rtl/bcd_polarity.sv
module bcd_polarity #(
    parameter int unsigned WIDTH      = 10,
    parameter bit          ACTIVE_LOW = 1'b1
) (
    input  logic [WIDTH-1:0] hot_i,
    output logic [WIDTH-1:0] pin_o
);
    if (ACTIVE_LOW) begin : g_low
        assign pin_o = ~hot_i;
    end else begin : g_high
        assign pin_o = hot_i;
    end
endmodule

// File: rtl/bcd_onehot_dec.sv
module bcd_onehot_dec
    import bcd_dec_pkg::*;
(
    input  logic [3:0] code_i,
    output logic [9:0] sel_n_o,
    output logic       invalid_o
);
    dec_t dec_d;
    logic bad_w;
    sel_t hot_w;

    bcd_range_chk #(.CODE_W(CODE_W), .LIMIT(DIGITS)) u_range (
        .code_i (code_i),
        .bad_o  (bad_w)
    );

    bcd_onehot_gen #(.CODE_W(CODE_W), .DIGITS(DIGITS)) u_gen (
        .code_i   (code_i),
        .enable_i (!bad_w),
        .hot_o    (hot_w)
    );

    always_comb begin
        dec_d.sel_hot = hot_w;
        dec_d.bad     = bad_w;
    end

    bcd_polarity #(.WIDTH(DIGITS), .ACTIVE_LOW(1'b1)) u_pol (
        .hot_i (dec_d.sel_hot),
        .pin_o (sel_n_o)
    );

    assign invalid_o = dec_d.bad;
endmodule

// File: rtl/bcd_onehot_dec_chk.sv
module bcd_onehot_dec_chk (
    input logic [3:0] code_i,
    input logic [9:0] sel_n_o,
    input logic       invalid_o
);
    always_comb begin
        p_at_most_one_low_r5: assert final ($countones(~sel_n_o) <= 1)
            else $error("R5 more than one select low");
        p_refused_all_high_r3: assert final (!invalid_o || (&sel_n_o))
            else $error("R3 select low on refused code");
        p_legal_one_low_r2: assert final (invalid_o || ($countones(~sel_n_o) == 1))
            else $error("R2 legal code without single select");
        p_flag_range_r4: assert final (invalid_o == (code_i > 4'd9))
            else $error("R4 flag mismatch");
        p_index_r1: assert final ((code_i > 4'd9) || !sel_n_o[code_i])
            else $error("R1 wrong line selected");
    end
endmodule

bind bcd_onehot_dec bcd_onehot_dec_chk u_chk (
    .code_i    (code_i),
    .sel_n_o   (sel_n_o),
    .invalid_o (invalid_o)
);

// File: tb/bcd_onehot_dec_bench.sv
module bcd_onehot_dec_bench;
    logic       clk = 1'b0;
    logic [3:0] code;
    logic [9:0] sel_n;
    logic       inval;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bcd_onehot_dec u_bcd_onehot_dec (
        .code_i    (code),
        .sel_n_o   (sel_n),
        .invalid_o (inval)
    );

    // {code, expected sel_n, expected invalid}
    localparam logic [14:0] VEC [16] = '{
        {4'd0,  10'b1111111110, 1'b0},
        {4'd1,  10'b1111111101, 1'b0},
        {4'd2,  10'b1111111011, 1'b0},
        {4'd3,  10'b1111110111, 1'b0},
        {4'd4,  10'b1111101111, 1'b0},
        {4'd5,  10'b1111011111, 1'b0},
        {4'd6,  10'b1110111111, 1'b0},
        {4'd7,  10'b1101111111, 1'b0},
        {4'd8,  10'b1011111111, 1'b0},
        {4'd9,  10'b0111111111, 1'b0},
        {4'd10, 10'b1111111111, 1'b1},
        {4'd11, 10'b1111111111, 1'b1},
        {4'd12, 10'b1111111111, 1'b1},
        {4'd13, 10'b1111111111, 1'b1},
        {4'd14, 10'b1111111111, 1'b1},
        {4'd15, 10'b1111111111, 1'b1}
    };

    task automatic expect_out(input string req, input logic [9:0] es, input logic ei);
        checks++;
        if (sel_n !== es || inval !== ei) begin
            errors++;
            $display("FAIL %s code=%0d sel_n=%b inv=%b expected sel_n=%b inv=%b",
                     req, code, sel_n, inval, es, ei);
        end
    endtask

    task automatic apply(input logic [3:0] c);
        @(negedge clk);
        code = c;
        #3;
    endtask

    initial begin
        code = 4'd0;
        #5;
        // R2: initial code 0 selects line 0
        expect_out("R2", 10'b1111111110, 1'b0);

        // R1 R2 R3 R4: full table
        for (int i = 0; i < 16; i++) begin
            apply(VEC[i][14:11]);
            expect_out(i < 10 ? "R2" : "R3/R4", VEC[i][10:1], VEC[i][0]);
            checks++;
            if ($countones(~sel_n) > 1) begin
                errors++;
                $display("FAIL R5 code=%0d low=%0d expected <=1", code, $countones(~sel_n));
            end
        end

        // R1: single-weight codes exercise bit order
        apply(4'b1000); expect_out("R1", 10'b1011111111, 1'b0);
        apply(4'b0001); expect_out("R1", 10'b1111111101, 1'b0);
        // boundary 9 to 10
        apply(4'd9);  expect_out("R4", 10'b0111111111, 1'b0);
        apply(4'd10); expect_out("R4", 10'b1111111111, 1'b1);

        // R6: same code after different predecessors
        apply(4'd15); apply(4'd5); expect_out("R6", 10'b1111011111, 1'b0);
        apply(4'd0);  apply(4'd5); expect_out("R6", 10'b1111011111, 1'b0);
        apply(4'd3);  apply(4'd12); expect_out("R6", 10'b1111111111, 1'b1);
        apply(4'd9);  apply(4'd12); expect_out("R6", 10'b1111111111, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule